// File: doc/BRIEF.md
# Dual-Trace Display Memory Controller

The controller runs a 1024-word by 8-bit display memory that holds two traces side by side. Each even address belongs to the stored trace and each odd address belongs to the live refresh trace, so the address LSB picks the trace and the upper nine bits pick the point. A single scan counter steps through the memory. Each memory cycle lasts two clocks: a read phase, then a write phase. The counter advances after every write phase.

A small sequencer decides what happens to the address LSB and to the write data in each phase. It has four states, encoded in two bits:

- `ST_NORMAL` (0) shows only the refresh trace and never writes.
- `ST_ACQUIRE` (1) writes converter samples into the refresh trace.
- `ST_BOTH` (2) alternates a refresh-trace half-scan with a stored-trace half-scan and drives the fast-sweep flag. In this state the clear button wipes the refresh trace and the blank button hides the stored trace.
- `ST_XFER` (3) copies every refresh point onto its stored neighbour through an 8-bit holding latch.

The transitions are:

- NORMAL to ACQUIRE when the clear button is pressed.
- NORMAL or ACQUIRE to BOTH on a rising edge of the store button. The store press has priority over clear.
- BOTH to XFER at the first full counter wrap after the store button has been released.
- XFER back to BOTH after 512 address pairs, with a one-cycle done pulse.

Every state change restarts the counter at zero in the read phase.

Top module: `dtm_ctrl`

## Requirements
- R1: While reset is applied, the outputs read as follows: sequencer state 0, counter zero, read phase (`mem_phase`=0), `mem_addr`=1, and `mem_we`, `sweep_sync`, `xfer_done` and `fast_sweep` all 0.
- R2: In state 0 the memory is never written and `mem_addr` bit 0 is always 1. A clear press moves the sequencer to state 1 and a store rising edge moves it to state 2. Each move restarts the counter at zero in the read phase.
- R3: In state 1 `mem_we` is 1 only in the write phase (`mem_phase`=1). Each write goes to address {counter[8:0],1} with `mem_wdata` equal to `adc_data`. `mem_we` is never 1 in the read phase in any state.
- R4: In state 2 `mem_addr` is {counter[8:0], ~counter[9]}. A pass therefore scans addresses 1,3,...,1023 first and then 0,2,...,1022. Each address is held for one read clock and one write clock.
- R5: `fast_sweep` is 1 in state 2 and 0 in every other state.
- R6: `sweep_sync` is a one-clock pulse in the first clock after the counter's lower nine bits roll over from 511 to 0.
- R7: In state 2 with clear held, zeros are written in the write phase to odd addresses only. Each pass writes 512 words and even addresses keep their contents.
- R8: In state 2 with blank held, `mem_addr` bit 0 is 1 in both halves of the pass. Releasing blank restores the alternating scan at once.
- R9: After the store button falls in state 2, the sequencer enters state 3 at the edge that ends the next full-pass write phase (counter 1023). The counter restarts at zero in the read phase.
- R10: In state 3 the read phase addresses {counter[8:0],1} and latches `mem_rdata`. The write phase addresses {counter[8:0],0} and writes the latched word.
- R11: State 3 lasts exactly 1024 clocks. The sequencer then returns to state 2 with `xfer_done` high for one clock, and every even word equals its odd neighbour.
- R12: When clear and blank are both held in state 2, zeros are written to the odd address in both halves of the pass, giving 1024 writes per pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| store_btn | input | 1 | Store button level |
| clear_btn | input | 1 | Clear/write button level |
| blank_btn | input | 1 | Blank-stored-trace button level |
| adc_data | input | 8 | Converter sample |
| mem_rdata | input | 8 | Memory read data (combinational read) |
| mem_addr | output | 10 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable, write phase only |
| mem_phase | output | 1 | 0 = read phase, 1 = write phase |
| fast_sweep | output | 1 | Double-rate display sweep request |
| sweep_sync | output | 1 | Pulse at each half-memory wrap |
| xfer_done | output | 1 | Pulse when a transfer pass ends |
| seq_state | output | 2 | Sequencer state code |

## Verification
Clear and blank can act together in the both-traces state. Blank steers the address LSB and clear decides whether a write happens, so together they must make the clear write to refresh addresses in both halves of the pass. The bench holds both buttons for a whole pass that starts at a counter wrap. It counts write strobes, expecting twice the count seen with clear alone, and checks that every strobe carries zero data to an odd address. The store release can also fall in the same cycle as the full wrap; the sequencer OR-combines the pending flag with a same-cycle falling edge so that neither event is lost.

// File: rtl/dtm_pkg.sv
package dtm_pkg;
    typedef enum logic [1:0] {
        ST_NORMAL  = 2'd0,
        ST_ACQUIRE = 2'd1,
        ST_BOTH    = 2'd2,
        ST_XFER    = 2'd3
    } dtm_state_e;
endpackage

// File: rtl/dtm_scan.sv
module dtm_scan #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    output logic              phase,
    output logic [ADDR_W-1:0] cnt,
    output logic              wrap_half,
    output logic              wrap_full,
    output logic              sweep_sync
);
    localparam int IDX_W = ADDR_W - 1;
    localparam logic [ADDR_W-1:0] CNT_ONE = ADDR_W'(1);

    // last write phase of a half scan / of a full pass
    assign wrap_half = phase && (&cnt[IDX_W-1:0]);
    assign wrap_full = phase && (&cnt);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase      <= 1'b0;
            cnt        <= '0;
            sweep_sync <= 1'b0;
        end else begin
            phase      <= ~phase;
            sweep_sync <= wrap_half;
            if (phase) begin
                cnt <= cnt + CNT_ONE;
            end
        end
    end

    // R6: sync is a single-clock pulse
    a_r6_sync_single: assert property (@(posedge clk) disable iff (rst)
        sweep_sync |=> !sweep_sync);
endmodule

// File: rtl/dtm_seq.sv
module dtm_seq
    import dtm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       store_btn,
    input  logic       clear_btn,
    input  logic       wrap_full,
    input  logic       wrap_half,
    output dtm_state_e state,
    output logic       restart,
    output logic       xfer_done
);
    dtm_state_e state_n;
    logic       store_q;
    logic       rel_pend;
    logic       store_rise;
    logic       store_fall;

    assign store_rise = store_btn && !store_q;
    assign store_fall = !store_btn && store_q;

    // next-state and transition outputs
    always_comb begin
        state_n = state;
        unique case (state)
            ST_NORMAL: begin
                if (store_rise)     state_n = ST_BOTH;
                else if (clear_btn) state_n = ST_ACQUIRE;
            end
            ST_ACQUIRE: begin
                if (store_rise) state_n = ST_BOTH;
            end
            ST_BOTH: begin
                if (wrap_full && (rel_pend || store_fall)) state_n = ST_XFER;
            end
            ST_XFER: begin
                if (wrap_half) state_n = ST_BOTH;
            end
        endcase
    end

    assign restart = (state_n != state);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_NORMAL;
            store_q   <= 1'b0;
            rel_pend  <= 1'b0;
            xfer_done <= 1'b0;
        end else begin
            state     <= state_n;
            store_q   <= store_btn;
            rel_pend  <= (state == ST_BOTH) && (state_n == ST_BOTH)
                         && (rel_pend || store_fall);
            xfer_done <= (state == ST_XFER) && (state_n == ST_BOTH);
        end
    end

    // R11: the done pulse coincides with the return to both-traces display
    a_r11_done_in_both: assert property (@(posedge clk) disable iff (rst)
        xfer_done |-> (state == ST_BOTH && $past(state) == ST_XFER));
endmodule

// File: rtl/dtm_path.sv
module dtm_path
    import dtm_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  dtm_state_e        state,
    input  logic              phase,
    input  logic [ADDR_W-1:0] cnt,
    input  logic              clear_btn,
    input  logic              blank_btn,
    input  logic [DATA_W-1:0] adc_data,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we
);
    localparam int IDX_W = ADDR_W - 1;

    logic              sel_lsb;
    logic [DATA_W-1:0] hold_q;

    always_comb begin
        sel_lsb   = 1'b1;
        mem_we    = 1'b0;
        mem_wdata = adc_data;
        unique case (state)
            ST_NORMAL: begin
                sel_lsb = 1'b1;
            end
            ST_ACQUIRE: begin
                sel_lsb = 1'b1;
                mem_we  = phase;
            end
            ST_BOTH: begin
                sel_lsb = blank_btn ? 1'b1 : ~cnt[ADDR_W-1];
                if (clear_btn) begin
                    mem_wdata = '0;
                    mem_we    = phase && sel_lsb;
                end
            end
            ST_XFER: begin
                sel_lsb   = ~phase;
                mem_wdata = hold_q;
                mem_we    = phase;
            end
        endcase
    end

    assign mem_addr = {cnt[IDX_W-1:0], sel_lsb};

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (state == ST_XFER && !phase) begin
            hold_q <= mem_rdata;
        end
    end

    // R3: writes only in the write phase
    a_r3_we_write_phase: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> phase);
    // R7: clear writes zeros to refresh addresses only
    a_r7_clear_zero_odd: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BOTH && mem_we) |-> (mem_wdata == '0 && mem_addr[0]));
    // R10: transfer writes land on stored-trace addresses
    a_r10_xfer_even_write: assert property (@(posedge clk) disable iff (rst)
        (state == ST_XFER && mem_we) |-> !mem_addr[0]);
endmodule

// File: rtl/dtm_ctrl.sv
module dtm_ctrl
    import dtm_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              store_btn,
    input  logic              clear_btn,
    input  logic              blank_btn,
    input  logic [DATA_W-1:0] adc_data,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_phase,
    output logic              fast_sweep,
    output logic              sweep_sync,
    output logic              xfer_done,
    output logic [1:0]        seq_state
);
    dtm_state_e        state;
    logic              restart;
    logic              phase;
    logic [ADDR_W-1:0] cnt;
    logic              wrap_half;
    logic              wrap_full;

    dtm_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .store_btn (store_btn),
        .clear_btn (clear_btn),
        .wrap_full (wrap_full),
        .wrap_half (wrap_half),
        .state     (state),
        .restart   (restart),
        .xfer_done (xfer_done)
    );

    dtm_scan #(.ADDR_W(ADDR_W)) u_scan (
        .clk        (clk),
        .rst        (rst),
        .restart    (restart),
        .phase      (phase),
        .cnt        (cnt),
        .wrap_half  (wrap_half),
        .wrap_full  (wrap_full),
        .sweep_sync (sweep_sync)
    );

    dtm_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_path (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .phase     (phase),
        .cnt       (cnt),
        .clear_btn (clear_btn),
        .blank_btn (blank_btn),
        .adc_data  (adc_data),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we)
    );

    assign mem_phase  = phase;
    assign fast_sweep = (state == ST_BOTH);
    assign seq_state  = state;

    // R9: a transfer pass begins at counter zero in the read phase
    a_r9_xfer_entry: assert property (@(posedge clk) disable iff (rst)
        (state == ST_XFER && $past(state) == ST_BOTH) |-> (cnt == '0 && !phase));
endmodule

// File: tb/test_dtm_ctrl.sv
module test_dtm_ctrl;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        int         off;
        logic [9:0] addr;
        logic       ph;
        logic       sync;
    } vec_t;

    // R4/R6 scan vectors: offset from entry into state 2
    localparam vec_t VEC [12] = '{
        '{0,    10'd1,    1'b0, 1'b0},
        '{1,    10'd1,    1'b1, 1'b0},
        '{2,    10'd3,    1'b0, 1'b0},
        '{3,    10'd3,    1'b1, 1'b0},
        '{1022, 10'd1023, 1'b0, 1'b0},
        '{1023, 10'd1023, 1'b1, 1'b0},
        '{1024, 10'd0,    1'b0, 1'b1},
        '{1025, 10'd0,    1'b1, 1'b0},
        '{1026, 10'd2,    1'b0, 1'b0},
        '{2046, 10'd1022, 1'b0, 1'b0},
        '{2047, 10'd1022, 1'b1, 1'b0},
        '{2048, 10'd1,    1'b0, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       store_btn = 1'b0;
    logic       clear_btn = 1'b0;
    logic       blank_btn = 1'b0;
    logic [7:0] adc_data = 8'h3C;
    logic [7:0] mem_rdata;
    logic [9:0] mem_addr;
    logic [7:0] mem_wdata;
    logic       mem_we;
    logic       mem_phase;
    logic       fast_sweep;
    logic       sweep_sync;
    logic       xfer_done;
    logic [1:0] seq_state;

    logic [7:0] mem  [1024];
    logic [7:0] snap [512];
    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dtm_ctrl i_dtm_ctrl (
        .clk        (clk),
        .rst        (rst),
        .store_btn  (store_btn),
        .clear_btn  (clear_btn),
        .blank_btn  (blank_btn),
        .adc_data   (adc_data),
        .mem_rdata  (mem_rdata),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_we     (mem_we),
        .mem_phase  (mem_phase),
        .fast_sweep (fast_sweep),
        .sweep_sync (sweep_sync),
        .xfer_done  (xfer_done),
        .seq_state  (seq_state)
    );

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 1024; i++)
                mem[i] <= i[0] ? (i[8:1] ^ 8'hA5) : 8'h5A;
        end else if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
        end
    end
    assign mem_rdata = mem[mem_addr];

    task automatic chk(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int cur, n, bad, w;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1", "state", int'(seq_state), 0);
        chk("R1", "phase", int'(mem_phase), 0);
        chk("R1", "addr", int'(mem_addr), 1);
        chk("R1", "we/sync/done/fast", int'({mem_we, sweep_sync, xfer_done, fast_sweep}), 0);
        rst = 1'b0;

        // R2 normal state: no writes, odd addresses only
        bad = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (mem_we || !mem_addr[0] || seq_state != 2'd0 || fast_sweep) bad++;
        end
        chk("R2", "normal idle violations", bad, 0);

        // R2/R3 clear press enters acquire
        clear_btn = 1'b1;
        @(negedge clk);
        chk("R2", "acquire state", int'(seq_state), 1);
        chk("R2", "restart phase/addr", int'({mem_phase, mem_addr}), 1);
        chk("R3", "no write in read phase", int'(mem_we), 0);
        clear_btn = 1'b0;
        @(negedge clk);
        chk("R3", "write phase we/addr", int'({mem_we, mem_addr}), int'({1'b1, 10'd1}));
        chk("R3", "write data", int'(mem_wdata), 8'h3C);
        @(negedge clk);
        chk("R3", "mem[1] written", int'(mem[1]), 8'h3C);
        chk("R3", "next addr", int'(mem_addr), 3);
        @(negedge clk);

        // R2/R4/R5/R6 store press, then walk the scan vectors
        store_btn = 1'b1;
        @(negedge clk);
        cur = 0;
        foreach (VEC[j]) begin
            while (cur < VEC[j].off) begin
                @(negedge clk);
                cur++;
            end
            chk("R4", $sformatf("addr off %0d", VEC[j].off), int'(mem_addr), int'(VEC[j].addr));
            chk("R4", $sformatf("phase off %0d", VEC[j].off), int'(mem_phase), int'(VEC[j].ph));
            chk("R6", $sformatf("sync off %0d", VEC[j].off), int'(sweep_sync), int'(VEC[j].sync));
            chk("R5", $sformatf("fast/state off %0d", VEC[j].off),
                int'({fast_sweep, mem_we, seq_state}), int'({1'b1, 1'b0, 2'd2}));
        end

        // R8 blank during the stored half (offset 3074: counter 513, read phase)
        blank_btn = 1'b1;
        repeat (1026) @(negedge clk);
        chk("R8", "blank forces odd addr", int'(mem_addr), 3);
        blank_btn = 1'b0;
        #1;
        chk("R8", "release restores even addr", int'(mem_addr), 2);

        // R9 store release, transfer at next full wrap
        for (int i = 0; i < 512; i++) snap[i] = mem[2*i+1];
        store_btn = 1'b0;
        n = 0;
        while (seq_state != 2'd3 && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk("R9", "clocks to transfer", n, 1022);
        chk("R9", "entry phase/addr", int'({mem_phase, mem_addr}), 1);
        chk("R5", "fast low in transfer", int'(fast_sweep), 0);
        chk("R10", "no write in read phase", int'(mem_we), 0);
        @(negedge clk);
        chk("R10", "write addr/we", int'({mem_we, mem_addr}), int'({1'b1, 10'd0}));
        chk("R10", "latched data", int'(mem_wdata), int'(snap[0]));
        n = 1;
        while (!xfer_done && n < 1100) begin
            @(negedge clk);
            n++;
        end
        chk("R11", "transfer length", n, 1024);
        chk("R11", "back in state 2", int'(seq_state), 2);
        bad = 0;
        for (int i = 0; i < 512; i++)
            if (mem[2*i] != snap[i] || mem[2*i+1] != snap[i]) bad++;
        chk("R11", "copy mismatches", bad, 0);

        // R7 clear alone over one pass
        clear_btn = 1'b1;
        w = 0; bad = 0;
        for (int k = 0; k < 2048; k++) begin
            if (k > 0) @(negedge clk);
            if (mem_we) begin
                w++;
                if (mem_wdata != 8'h00 || !mem_addr[0]) bad++;
            end
        end
        @(negedge clk);
        chk("R7", "writes per pass", w, 512);
        chk("R7", "bad writes", bad, 0);
        bad = 0;
        for (int i = 0; i < 512; i++)
            if (mem[2*i+1] != 8'h00 || mem[2*i] != snap[i]) bad++;
        chk("R7", "memory after clear", bad, 0);

        // R12 clear and blank together
        blank_btn = 1'b1;
        w = 0; bad = 0;
        for (int k = 0; k < 2048; k++) begin
            if (k > 0) @(negedge clk);
            if (mem_we) begin
                w++;
                if (mem_wdata != 8'h00 || !mem_addr[0]) bad++;
            end
        end
        chk("R12", "writes per pass", w, 1024);
        chk("R12", "bad writes", bad, 0);
        clear_btn = 1'b0;
        blank_btn = 1'b0;
        @(negedge clk);
        bad = 0;
        for (int i = 0; i < 512; i++)
            if (mem[2*i] != snap[i]) bad++;
        chk("R12", "stored trace untouched", bad, 0);
        chk("R12", "state stays 2", int'(seq_state), 2);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule